// File: doc/BRIEF.md
# Converter Synchronization Bring-Up Sequencer

This block is a host-side controller that takes a data converter from reset into synchronized operation. It works only through a simple request/acknowledge register bus. It issues register writes and reads in a fixed order and decides each next step from the values it reads back. It first puts both analog outputs to sleep. It then programs the mode word and the FIFO phase offset, and enables the sync engine with one of two sampling edges. After that it polls the lock and lost status. When lock fails, it disables the engine, clears the lost flag and tries again on the opposite edge.

Once lock is reached, the sequencer enables the FIFO warning interrupt. It then reads the FIFO thermometer until it gets five identical values in a row. After that it reads the warning flags, and while any warning flag is set it clears the flags and repeats the check. Last, it wakes the outputs. An optional calibration pass turns the stable thermometer value into the best offset and keeps it for later runs. A one-time variant turns the sync engine off again right after lock. Every loop has a retry limit, and running out of retries ends the run in an error state with a code. A start pulse reruns the sequence.

Top module: `sync_bringup_seq`

## Requirements
- R1: After reset, busy, done, err, bus_req, err_code and cal_offset are all 0.
- R2: Only one bus transaction is in flight at a time. bus_req, bus_we, bus_addr and bus_wdata stay constant from the request until the cycle in which bus_ack is seen.
- R3: The first two writes set bit 7 (0x80) in the two output-control registers, at address 0x20 and then 0x21. The last two writes before done write 0x00 to 0x20 and then to 0x21.
- R4: The third write puts mode_cfg at 0x10. The fourth write puts the FIFO offset at 0x12: 0 when cal_en is set, otherwise the stored offset (0 after reset).
- R5: The sync control register at 0x14 is enabled with 0x88 for rising-edge sampling (edge 0) and with 0x80 for falling-edge sampling (edge 1). The first attempt uses start_edge.
- R6: The status register at 0x18 holds lost in bit 5 and locked in bit 4. The pair 01 means lock. The pair 00 means pending and is read again, up to LOCK_POLL_MAX reads. Any other pair, or polls running out, causes three writes: 0x00 to 0x14, then 0x20 to 0x18 (write-one-to-clear of lost), then the enable on the other edge. After EDGE_TRY_MAX failed attempts the run ends with err and err_code 1.
- R7: With once_mode set, 0x00 is written to 0x14 right after lock. The final flag check then also requires the lost bit to be clear.
- R8: After lock, the sequencer writes 0x03 to the interrupt enable at 0x16 and reads the thermometer at 0x1A until N_MATCH (5) consecutive reads are equal. A mismatching read becomes the new reference. After THERM_TRY_MAX mismatches the run ends with err and err_code 2.
- R9: With cal_en set, the stable thermometer value t gives v = (number of ones in t) − 1. The offset is 4 − v for v ≤ 4 and 12 − v otherwise. It appears on cal_offset and is used as the offset in later runs that have cal_en clear.
- R10: Bits 1:0 of 0x18 are warning flags. If either is set, the sequencer writes 0x00 to 0x16, then writes 0x03 to 0x18 (0x23 in once mode), re-enables the warnings and repeats the thermometer and flag checks. After WARN_TRY_MAX such rounds the run ends with err and err_code 3.
- R11: busy is high from start to the end of the run. done and err are held until the next start, and never both. A start pulse in idle, done or error begins a new run.
- R12: lock_edge reports the edge of the attempt that reached lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| start_edge | input | 1 | Edge of the first sync attempt, 0 rising, 1 falling |
| cal_en | input | 1 | Run the offset calibration pass |
| once_mode | input | 1 | Turn the sync engine off after lock |
| mode_cfg | input | 8 | Mode word written to the mode register |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished successfully |
| err | output | 1 | Run ended in error |
| err_code | output | 2 | 1 lock, 2 thermometer, 3 warning |
| lock_edge | output | 1 | Edge currently in use |
| cal_offset | output | 3 | Stored calibrated offset |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | Write when high, read when low |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge from the device |
| bus_rdata | input | 8 | Read data, valid with bus_ack |

## Verification
The bench starts runs on the wrong edge and checks for the exact disable, clear-lost and re-enable writes. A design that re-enabled on the same edge, or skipped the clear, would leave a visibly wrong write log and lock_edge value. It drives lock delays on both sides of the poll limit and a device that never locks, to catch an off-by-one in the retry counters. A single thermometer glitch must still end in done, while an always-toggling thermometer must end in error code 2. Calibration is checked across thermometer values on both sides of the wrap-around, and the stored result must show up as the offset write of the next run. Sticky warning flags must produce the clear-and-recheck writes or error code 3.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int AW = 8;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_OUT0  = 8'h20;
  localparam logic [AW-1:0] A_OUT1  = 8'h21;
  localparam logic [AW-1:0] A_MODE  = 8'h10;
  localparam logic [AW-1:0] A_OFFS  = 8'h12;
  localparam logic [AW-1:0] A_SYNC  = 8'h14;
  localparam logic [AW-1:0] A_IRQ   = 8'h16;
  localparam logic [AW-1:0] A_STAT  = 8'h18;
  localparam logic [AW-1:0] A_THERM = 8'h1A;

  localparam logic [DW-1:0] SLEEP_ON  = 8'h80;
  localparam logic [DW-1:0] SYNC_RISE = 8'h88;
  localparam logic [DW-1:0] SYNC_FALL = 8'h80;
  localparam logic [DW-1:0] IRQ_WARN  = 8'h03;
  localparam logic [DW-1:0] CLR_LOST  = 8'h20;
  localparam logic [DW-1:0] CLR_WARN  = 8'h03;

  localparam int LOST_BIT = 5;
  localparam int LOCK_BIT = 4;

  typedef enum logic [1:0] {
    E_NONE  = 2'd0,
    E_LOCK  = 2'd1,
    E_THERM = 2'd2,
    E_WARN  = 2'd3
  } err_e;

  typedef enum logic [4:0] {
    S_IDLE, S_SLP0, S_SLP1, S_MODE, S_OFFS, S_SYNC, S_LOCK, S_SOFF,
    S_LCLR, S_ONCE, S_WEN, S_THERM, S_FLAG, S_WDIS, S_FCLR, S_WK0,
    S_WK1, S_DONE, S_ERR
  } st_e;
endpackage

// File: rtl/sbs_bus_port.sv
module sbs_bus_port
  import sbs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req <= 1'b0;
          done    <= 1'b1;
          rdata   <= bus_rdata;
        end
      end else if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));

  // R2
  one_txn_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> !bus_req && !done);
endmodule

// File: rtl/sbs_try_cnt.sv
module sbs_try_cnt #(
  parameter int MAX = 4,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != W'(MAX - 1)) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(MAX - 1));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(MAX - 1));
endmodule

// File: rtl/sbs_therm_calc.sv
module sbs_therm_calc #(
  parameter int DEPTH = 8,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] code,
  output logic [OW-1:0]    offset
);
  localparam int HALF = DEPTH / 2;
  int ones;
  int v;

  always_comb begin
    ones = 0;
    for (int i = 0; i < DEPTH; i++) ones = ones + int'(code[i]);
    v = (ones > 0) ? ones - 1 : 0;
    if (v <= HALF) offset = OW'(HALF - v);
    else           offset = OW'(DEPTH + HALF - v);
  end
endmodule

// File: rtl/sync_bringup_seq.sv
module sync_bringup_seq
  import sbs_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int LOCK_POLL_MAX = 8,
  parameter int EDGE_TRY_MAX  = 4,
  parameter int THERM_TRY_MAX = 4,
  parameter int WARN_TRY_MAX  = 4,
  parameter int N_MATCH       = 5,
  localparam int OW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_edge,
  input  logic          cal_en,
  input  logic          once_mode,
  input  logic [7:0]    mode_cfg,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_code,
  output logic          lock_edge,
  output logic [OW-1:0] cal_offset,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  st_e           state;
  logic          pend;
  logic          edge_q, cal_q, once_q;
  logic [7:0]    mode_q;
  logic [OW-1:0] saved_q;
  logic [DW-1:0] ref_q;
  logic          have_ref;

  logic          op_act, op_we, op_go, op_done;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wd, rd;
  logic [OW-1:0] calc_off;

  logic start_acc;
  logic poll_clr, poll_inc, poll_last;
  logic edge_inc, edge_last;
  logic th_inc, th_last;
  logic w_inc, w_last;
  logic m_clr, m_inc, m_last;

  logic [1:0] lk_pair;
  logic       rd_match, flag_bad;

  assign start_acc = start && (state == S_IDLE || state == S_DONE || state == S_ERR);
  assign lk_pair   = {rd[LOST_BIT], rd[LOCK_BIT]};
  assign rd_match  = (rd == ref_q);
  assign flag_bad  = (|rd[1:0]) || (once_q && rd[LOST_BIT]);

  // one register access per step
  always_comb begin
    op_act  = 1'b1;
    op_we   = 1'b1;
    op_addr = A_OUT0;
    op_wd   = '0;
    unique case (state)
      S_SLP0:  begin op_addr = A_OUT0; op_wd = SLEEP_ON; end
      S_SLP1:  begin op_addr = A_OUT1; op_wd = SLEEP_ON; end
      S_MODE:  begin op_addr = A_MODE; op_wd = mode_q; end
      S_OFFS:  begin op_addr = A_OFFS; op_wd = cal_q ? '0 : DW'(saved_q); end
      S_SYNC:  begin op_addr = A_SYNC; op_wd = edge_q ? SYNC_FALL : SYNC_RISE; end
      S_LOCK:  begin op_we = 1'b0; op_addr = A_STAT; end
      S_SOFF:  begin op_addr = A_SYNC; op_wd = '0; end
      S_LCLR:  begin op_addr = A_STAT; op_wd = CLR_LOST; end
      S_ONCE:  begin op_addr = A_SYNC; op_wd = '0; end
      S_WEN:   begin op_addr = A_IRQ; op_wd = IRQ_WARN; end
      S_THERM: begin op_we = 1'b0; op_addr = A_THERM; end
      S_FLAG:  begin op_we = 1'b0; op_addr = A_STAT; end
      S_WDIS:  begin op_addr = A_IRQ; op_wd = '0; end
      S_FCLR:  begin op_addr = A_STAT; op_wd = once_q ? (CLR_WARN | CLR_LOST) : CLR_WARN; end
      S_WK0:   begin op_addr = A_OUT0; op_wd = '0; end
      S_WK1:   begin op_addr = A_OUT1; op_wd = '0; end
      default: op_act = 1'b0;
    endcase
  end

  assign op_go = op_act && !pend;

  // counter controls
  always_comb begin
    poll_clr = start_acc || (op_done && state == S_SYNC);
    poll_inc = op_done && state == S_LOCK && lk_pair == 2'b00 && !poll_last;
    edge_inc = op_done && state == S_LOCK && lk_pair != 2'b01
               && !(lk_pair == 2'b00 && !poll_last) && !edge_last;
    th_inc   = op_done && state == S_THERM && have_ref && !rd_match && !th_last;
    m_clr    = start_acc || (op_done && state == S_WEN) ||
               (op_done && state == S_THERM && have_ref && !rd_match);
    m_inc    = op_done && state == S_THERM && have_ref && rd_match && !m_last;
    w_inc    = op_done && state == S_FLAG && flag_bad && !w_last;
  end

  sbs_bus_port i_port (
    .clk(clk), .rst(rst), .go(op_go), .we(op_we), .addr(op_addr), .wdata(op_wd),
    .done(op_done), .rdata(rd),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  sbs_try_cnt #(.MAX(LOCK_POLL_MAX)) i_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last));
  sbs_try_cnt #(.MAX(EDGE_TRY_MAX)) i_edge (
    .clk(clk), .rst(rst), .clr(start_acc), .inc(edge_inc), .last(edge_last));
  sbs_try_cnt #(.MAX(THERM_TRY_MAX)) i_therm (
    .clk(clk), .rst(rst), .clr(start_acc), .inc(th_inc), .last(th_last));
  sbs_try_cnt #(.MAX(WARN_TRY_MAX)) i_warn (
    .clk(clk), .rst(rst), .clr(start_acc), .inc(w_inc), .last(w_last));
  sbs_try_cnt #(.MAX(N_MATCH - 1)) i_match (
    .clk(clk), .rst(rst), .clr(m_clr), .inc(m_inc), .last(m_last));

  sbs_therm_calc #(.DEPTH(DEPTH)) i_calc (.code(rd[DEPTH-1:0]), .offset(calc_off));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pend     <= 1'b0;
      edge_q   <= 1'b0;
      cal_q    <= 1'b0;
      once_q   <= 1'b0;
      mode_q   <= '0;
      saved_q  <= '0;
      ref_q    <= '0;
      have_ref <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= E_NONE;
    end else begin
      if (op_go) pend <= 1'b1;
      if (start_acc) begin
        state    <= S_SLP0;
        edge_q   <= start_edge;
        cal_q    <= cal_en;
        once_q   <= once_mode;
        mode_q   <= mode_cfg;
        busy     <= 1'b1;
        done     <= 1'b0;
        err      <= 1'b0;
        err_code <= E_NONE;
      end else if (op_done) begin
        pend <= 1'b0;
        unique case (state)
          S_SLP0: state <= S_SLP1;
          S_SLP1: state <= S_MODE;
          S_MODE: state <= S_OFFS;
          S_OFFS: state <= S_SYNC;
          S_SYNC: state <= S_LOCK;
          S_LOCK: begin
            if (lk_pair == 2'b01) begin
              state <= once_q ? S_ONCE : S_WEN;
            end else if (lk_pair == 2'b00 && !poll_last) begin
              state <= S_LOCK;
            end else if (edge_last) begin
              state    <= S_ERR;
              busy     <= 1'b0;
              err      <= 1'b1;
              err_code <= E_LOCK;
            end else begin
              state <= S_SOFF;
            end
          end
          S_SOFF: begin
            edge_q <= ~edge_q;
            state  <= S_LCLR;
          end
          S_LCLR: state <= S_SYNC;
          S_ONCE: state <= S_WEN;
          S_WEN: begin
            have_ref <= 1'b0;
            state    <= S_THERM;
          end
          S_THERM: begin
            if (!have_ref) begin
              ref_q    <= rd;
              have_ref <= 1'b1;
            end else if (rd_match) begin
              if (m_last) begin
                if (cal_q) saved_q <= calc_off;
                state <= S_FLAG;
              end
            end else if (th_last) begin
              state    <= S_ERR;
              busy     <= 1'b0;
              err      <= 1'b1;
              err_code <= E_THERM;
            end else begin
              ref_q <= rd;
            end
          end
          S_FLAG: begin
            if (!flag_bad) begin
              state <= S_WK0;
            end else if (w_last) begin
              state    <= S_ERR;
              busy     <= 1'b0;
              err      <= 1'b1;
              err_code <= E_WARN;
            end else begin
              state <= S_WDIS;
            end
          end
          S_WDIS: state <= S_FCLR;
          S_FCLR: state <= S_WEN;
          S_WK0:  state <= S_WK1;
          S_WK1: begin
            state <= S_DONE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
          default: state <= state;
        endcase
      end
    end
  end

  assign lock_edge  = edge_q;
  assign cal_offset = saved_q;

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R11
  busy_flags_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done && !err);

  // R5
  sync_val_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == A_SYNC |->
      (bus_wdata == SYNC_RISE || bus_wdata == SYNC_FALL || bus_wdata == 8'h00));

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !bus_req);

  // R11
  done_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> err_code == E_NONE);
endmodule

// File: tb/test_sync_bringup_seq.sv
module test_sync_bringup_seq;
  import sbs_pkg::*;

  localparam int LPM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, start_edge = 1'b0, cal_en = 1'b0, once_mode = 1'b0;
  logic [7:0] mode_cfg = 8'h00;
  logic busy, done, err, lock_edge;
  logic [1:0] err_code;
  logic [2:0] cal_offset;
  logic bus_req, bus_we, bus_ack;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  sync_bringup_seq i_sync_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .start_edge(start_edge), .cal_en(cal_en),
    .once_mode(once_mode), .mode_cfg(mode_cfg), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .lock_edge(lock_edge), .cal_offset(cal_offset),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // device model knobs
  int good_edge = 0;     // 0 rising, 1 falling, 2 never
  int lock_delay = 0;
  int therm_mode = 0;    // 0 steady, 1 one glitch, 2 toggling
  int warn_max = 0;
  logic [7:0] therm_val = 8'h0F;
  logic mclr = 1'b0;

  // device model state
  logic [7:0] m_sync;
  logic       m_lost, wait_q;
  logic [1:0] m_warn;
  int lock_cnt, therm_reads, warn_cnt, wn;
  logic [15:0] wlog [0:255];

  function automatic logic edge_good(input logic [7:0] s);
    return (good_edge != 2) && ((s == SYNC_FALL) == (good_edge == 1));
  endfunction

  always @(posedge clk) begin
    if (rst || mclr) begin
      bus_ack <= 1'b0; wait_q <= 1'b0; m_sync <= 8'h00; m_lost <= 1'b0; m_warn <= 2'b00;
      lock_cnt <= 0; therm_reads <= 0; warn_cnt <= 0; wn <= 0; bus_rdata <= 8'h00;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (!wait_q) wait_q <= 1'b1;
        else begin
          wait_q  <= 1'b0;
          bus_ack <= 1'b1;
          if (bus_we) begin
            if (wn < 256) wlog[wn] <= {bus_addr, bus_wdata};
            wn <= wn + 1;
            if (bus_addr == A_SYNC) begin m_sync <= bus_wdata; lock_cnt <= 0; end
            if (bus_addr == A_STAT) begin
              if (bus_wdata[5]) m_lost <= 1'b0;
              m_warn <= m_warn & ~bus_wdata[1:0];
            end
            if (bus_addr == A_IRQ && bus_wdata == 8'h03 && warn_cnt < warn_max) begin
              m_warn <= 2'b01; warn_cnt <= warn_cnt + 1;
            end
          end else if (bus_addr == A_STAT) begin
            if (m_sync[7] && edge_good(m_sync)) begin
              if (lock_cnt < lock_delay) begin
                lock_cnt <= lock_cnt + 1;
                bus_rdata <= {2'b00, m_lost, 1'b0, 2'b00, m_warn};
              end else bus_rdata <= {2'b00, m_lost, 1'b1, 2'b00, m_warn};
            end else if (m_sync[7]) begin
              m_lost <= 1'b1;
              bus_rdata <= {2'b00, 1'b1, 1'b0, 2'b00, m_warn};
            end else bus_rdata <= {2'b00, m_lost, 1'b0, 2'b00, m_warn};
          end else if (bus_addr == A_THERM) begin
            therm_reads <= therm_reads + 1;
            if ((therm_mode == 1 && therm_reads == 2) || (therm_mode == 2 && therm_reads[0]))
              bus_rdata <= therm_val ^ 8'h80;
            else bus_rdata <= therm_val;
          end else bus_rdata <= 8'h00;
        end
      end
    end
  end

  int tests = 0, fails = 0;
  logic [2:0] exp_saved = 3'd0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_off(input logic [7:0] t);
    int ones = 0;
    int v;
    for (int i = 0; i < 8; i++) ones += int'(t[i]);
    v = (ones > 0) ? ones - 1 : 0;
    return (v <= 4) ? 3'(4 - v) : 3'(12 - v);
  endfunction

  task automatic run(input logic se, input logic ce, input logic om, input logic [7:0] md);
    int n = 0;
    @(negedge clk);
    start_edge = se; cal_en = ce; once_mode = om; mode_cfg = md;
    mclr = 1'b1;
    @(negedge clk);
    mclr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(done || err) && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check("R11 run timeout", 0, 1);
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0); check("R1 done", done, 0); check("R1 err", err, 0);
    check("R1 bus_req", bus_req, 0); check("R1 cal_offset", cal_offset, 0);
    rst = 1'b0;
    @(negedge clk);

    // directed: rising lock first try
    good_edge = 0; lock_delay = 0; therm_mode = 0; warn_max = 0; therm_val = 8'h0F;
    run(1'b0, 1'b0, 1'b0, 8'h5A);
    check("R11 done", done, 1); check("R11 err", err, 0); check("R11 busy", busy, 0);
    check("R3 sleep0", wlog[0], {A_OUT0, 8'h80}); check("R3 sleep1", wlog[1], {A_OUT1, 8'h80});
    check("R4 mode", wlog[2], {A_MODE, 8'h5A}); check("R4 offset", wlog[3], {A_OFFS, 8'h00});
    check("R5 rise", wlog[4], {A_SYNC, SYNC_RISE}); check("R8 irq", wlog[5], {A_IRQ, 8'h03});
    check("R3 wake0", wlog[wn-2], {A_OUT0, 8'h00}); check("R3 wake1", wlog[wn-1], {A_OUT1, 8'h00});
    check("R12 edge", lock_edge, 0);

    // R6 retry on the other edge
    good_edge = 1;
    run(1'b0, 1'b0, 1'b0, 8'h11);
    check("R6 done", done, 1); check("R6 off", wlog[5], {A_SYNC, 8'h00});
    check("R6 clr lost", wlog[6], {A_STAT, CLR_LOST}); check("R5 fall", wlog[7], {A_SYNC, SYNC_FALL});
    check("R12 edge", lock_edge, 1);

    // R6 never locks
    good_edge = 2;
    run(1'b1, 1'b0, 1'b0, 8'h00);
    check("R6 err", err, 1); check("R6 code", err_code, 1); check("R11 done low", done, 0);

    // R6 poll limit boundary
    good_edge = 0; lock_delay = LPM - 1;
    run(1'b0, 1'b0, 1'b0, 8'h00);
    check("R6 delay in limit", done, 1);
    lock_delay = LPM;
    run(1'b0, 1'b0, 1'b0, 8'h00);
    check("R6 delay over limit", err_code, 1);
    lock_delay = 0;

    // R7 one-time variant
    run(1'b0, 1'b0, 1'b1, 8'h00);
    check("R7 done", done, 1); check("R7 sync off", wlog[5], {A_SYNC, 8'h00});
    check("R7 irq after", wlog[6], {A_IRQ, 8'h03});

    // R8 thermometer stability
    therm_mode = 1;
    run(1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 glitch tolerated", done, 1);
    therm_mode = 2;
    run(1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 toggling err", err, 1); check("R8 code", err_code, 2);
    therm_mode = 0;

    // R9 calibration and reuse
    therm_val = 8'h3F;
    run(1'b0, 1'b1, 1'b0, 8'h00);
    exp_saved = exp_off(8'h3F);
    check("R9 cal 0x3F", cal_offset, 7); check("R4 cal offset 0", wlog[3], {A_OFFS, 8'h00});
    run(1'b0, 1'b0, 1'b0, 8'h00);
    check("R9 reuse", wlog[3], {A_OFFS, 8'h07});
    therm_val = 8'h1F;
    run(1'b0, 1'b1, 1'b0, 8'h00);
    exp_saved = exp_off(8'h1F);
    check("R9 cal 0x1F", cal_offset, 0);

    // R10 warning flags
    warn_max = 1;
    run(1'b0, 1'b0, 1'b0, 8'h00);
    check("R10 done", done, 1); check("R10 disable", wlog[6], {A_IRQ, 8'h00});
    check("R10 clear", wlog[7], {A_STAT, CLR_WARN}); check("R10 reenable", wlog[8], {A_IRQ, 8'h03});
    warn_max = 10;
    run(1'b0, 1'b0, 1'b0, 8'h00);
    check("R10 err", err, 1); check("R10 code", err_code, 3);
    warn_max = 0;

    // random runs
    for (int k = 0; k < 24; k++) begin
      logic se, ce;
      logic [7:0] tv, md;
      bit ok;
      se = 1'($urandom); ce = 1'($urandom); md = 8'($urandom);
      good_edge = int'($urandom % 3); lock_delay = int'($urandom % (LPM + 2));
      tv = 8'((9'd1 << (1 + ($urandom % 8))) - 9'd1);
      therm_val = tv;
      ok = (good_edge != 2) && (lock_delay < LPM);
      run(se, ce, 1'b0, md);
      check("R4 rnd offset", wlog[3], {A_OFFS, ce ? 8'h00 : {5'b0, exp_saved}});
      check("R6 rnd done", done, int'(ok));
      if (ok) begin
        check("R12 rnd edge", lock_edge, good_edge);
        if (ce) exp_saved = exp_off(tv);
        check("R9 rnd cal", cal_offset, exp_saved);
      end else check("R6 rnd code", err_code, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule